// File: doc/BRIEF.md
# Serial Clock Source Multiplexer

This block picks the clocks for one serial channel. There are six candidate sources: a crystal-oscillator clock, a baud-rate-generator output, the receive and transmit outputs of a digital PLL, a dedicated external clock pin, and a second clock pin that can work in either direction. A register holds the receive-clock, transmit-clock and pin-drive choices. It is loaded from a byte-wide write port. The block passes the chosen sources to the receiver and transmitter clock nets, and it applies the receive-path inversion. It also decides whether the bidirectional pin is driven and with what value.

The pin is driven only when it is asked to be an output and neither clock path is using it as a source. As an output it can carry a view of the transmit clock. This is the only way to reach the DPLL transmit output from outside the block. Clock selections should be settled before the downstream shifters, the baud-rate generator and the DPLL are running. Any write made while one of their enable inputs is high is reported on a one-cycle error flag.

Top module: `sclk_route`

## Requirements
- R1: After reset the stored configuration is all zeros. In this state `bpin_oe` is 0, `cfg_err` is 0, `rx_clk` equals the inverse of `xpin_clk` and `tx_clk` equals `xpin_clk`.
- R2: Write-data bits 6:5 pick the receive source: 00 `xpin_clk`, 01 `bpin_in`, 10 `brg_clk`, 11 `pll_rx_clk`. `rx_clk` is the logical inverse of the picked source, so a rising edge on the source is a falling edge on `rx_clk`, and that falling edge is the receive sampling edge.
- R3: Write-data bits 4:3 pick the transmit source, with no inversion: 00 `xpin_clk`, 01 `bpin_in`, 10 `brg_clk`, 11 `pll_tx_clk`.
- R4: `bpin_oe` is 1 only when all three of these hold: write-data bit 2 was stored as 1, the receive code is not 01, and the transmit code is not 01.
- R5: While `bpin_oe` is 1, bits 1:0 pick `bpin_out`: 00 the oscillator clock, 01 `tx_clk`, 10 `brg_clk`, 11 `pll_rx_clk`.
- R6: With pin code 00 and `osc_en` low, `bpin_out` is held at 1 while the pin is an output.
- R7: While `bpin_oe` is 0, `bpin_out` is 0.
- R8: A write on one rising edge takes effect in the outputs from that edge on. Without a write, the configuration holds. Write-data bit 7 has no effect on any output.
- R9: `cfg_err` is 1 for exactly the cycle after a write made while any bit of `run_en` is high. Otherwise it is 0. A flagged write is still stored.
- R10: With transmit code 11 and pin code 01, `bpin_out` follows `pll_tx_clk` while the pin is an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| run_en | input | 4 | Enables of the receiver, transmitter, baud-rate generator and DPLL |
| osc_clk | input | 1 | Crystal-oscillator clock |
| osc_en | input | 1 | Oscillator enabled |
| brg_clk | input | 1 | Baud-rate-generator output |
| pll_rx_clk | input | 1 | DPLL receive output |
| pll_tx_clk | input | 1 | DPLL transmit output |
| xpin_clk | input | 1 | External receive/transmit clock pin |
| bpin_in | input | 1 | Input side of the bidirectional clock pin |
| rx_clk | output | 1 | Receiver clock (inverted path) |
| tx_clk | output | 1 | Transmitter clock |
| bpin_oe | output | 1 | Output enable of the bidirectional pin |
| bpin_out | output | 1 | Output value of the bidirectional pin |
| cfg_err | output | 1 | Write made while a downstream function is enabled |

## Verification
There are two timings to follow.

The configuration and the error flag are registered. A write presented before a rising edge therefore shows in `rx_clk`, `tx_clk`, `bpin_oe`, `bpin_out` and `cfg_err` at the falling edge right after that rising edge. The bench samples there, and it drops `cfg_we` at that point, so the flag must also clear by the following falling edge.

The clock outputs follow their source inputs with no register in between. The bench changes the source inputs at a falling edge and compares all outputs 1 ns later against a behavioural model. It does this for all 256 write values and all 128 combinations of the source inputs, including every case with the oscillator off.

// File: rtl/sclk_route_pkg.sv
package sclk_route_pkg;

    // Clock source codes for the receive and transmit paths
    typedef enum logic [1:0] {
        SRC_XPIN = 2'b00,
        SRC_BPIN = 2'b01,
        SRC_BRG  = 2'b10,
        SRC_PLL  = 2'b11
    } clk_src_e;

    // What the bidirectional pin carries when it is an output
    typedef enum logic [1:0] {
        PO_OSC   = 2'b00,
        PO_TXC   = 2'b01,
        PO_BRG   = 2'b10,
        PO_PLLRX = 2'b11
    } pin_src_e;

    // Field order follows the write-data bit positions 6..0
    typedef struct packed {
        clk_src_e rx_src;     // bits 6:5
        clk_src_e tx_src;     // bits 4:3
        logic     pin_req;    // bit 2
        pin_src_e pin_src;    // bits 1:0
    } clk_cfg_t;

endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
    import sclk_route_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_RUN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_RUN-1:0]  run_en,
    output clk_cfg_t          cfg_o,
    output logic              err_o
);

    localparam int CFG_BITS = $bits(clk_cfg_t);

    typedef struct packed {
        clk_cfg_t cfg;
        logic     err;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = we && (|run_en);
        if (we) begin
            st_d.cfg = clk_cfg_t'(wdata[CFG_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign err_o = st_q.err;

    logic [CFG_BITS-1:0] cfg_bits;
    assign cfg_bits = st_q.cfg;

    // R9: a write during activity is flagged on the next cycle
    a_r9_busy_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (|run_en)) |=> err_o);

    // R9: no write means no flag on the next cycle
    a_r9_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !err_o);

    // R8: configuration holds without a write
    a_r8_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_bits));

    // R8: the spare top bit never changes what is stored
    a_r8_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[DATA_W-1]) |=> (cfg_bits == $past(wdata[CFG_BITS-1:0])));

endmodule

// File: rtl/sclk_sel4.sv
module sclk_sel4 #(
    parameter bit INVERT = 1'b0,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] src,
    output logic                  clk_o
);

    localparam int N_SRC = 1 << SEL_W;

    logic [N_SRC-1:0] src_v;
    assign src_v = src;

    generate
        if (INVERT) begin : g_inv
            assign clk_o = ~src_v[sel];
        end else begin : g_direct
            assign clk_o = src_v[sel];
        end
    endgenerate

endmodule

// File: rtl/sclk_pin_ctl.sv
module sclk_pin_ctl
    import sclk_route_pkg::*;
(
    input  clk_cfg_t cfg,
    input  logic     osc_clk,
    input  logic     osc_en,
    input  logic     txc,
    input  logic     brg_clk,
    input  logic     pll_rx_clk,
    output logic     oe,
    output logic     pin_o
);

    logic drive_v;

    always_comb begin
        oe = cfg.pin_req && (cfg.rx_src != SRC_BPIN) && (cfg.tx_src != SRC_BPIN);
        unique case (cfg.pin_src)
            PO_OSC:   drive_v = osc_en ? osc_clk : 1'b1;
            PO_TXC:   drive_v = txc;
            PO_BRG:   drive_v = brg_clk;
            PO_PLLRX: drive_v = pll_rx_clk;
            default:  drive_v = 1'b1;
        endcase
        pin_o = oe ? drive_v : 1'b0;
    end

endmodule

// File: rtl/sclk_route.sv
module sclk_route
    import sclk_route_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_RUN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_RUN-1:0]  run_en,
    input  logic              osc_clk,
    input  logic              osc_en,
    input  logic              brg_clk,
    input  logic              pll_rx_clk,
    input  logic              pll_tx_clk,
    input  logic              xpin_clk,
    input  logic              bpin_in,
    output logic              rx_clk,
    output logic              tx_clk,
    output logic              bpin_oe,
    output logic              bpin_out,
    output logic              cfg_err
);

    localparam int SEL_W = $bits(clk_src_e);
    localparam int N_SRC = 1 << SEL_W;

    clk_cfg_t         cfg;
    logic [N_SRC-1:0] rx_srcs, tx_srcs;

    sclk_cfg_reg #(.DATA_W(DATA_W), .N_RUN(N_RUN)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .run_en (run_en),
        .cfg_o  (cfg),
        .err_o  (cfg_err)
    );

    // index follows the clk_src_e encoding
    assign rx_srcs = {pll_rx_clk, brg_clk, bpin_in, xpin_clk};
    assign tx_srcs = {pll_tx_clk, brg_clk, bpin_in, xpin_clk};

    sclk_sel4 #(.INVERT(1'b1), .SEL_W(SEL_W)) u_rx_sel (
        .sel   (cfg.rx_src),
        .src   (rx_srcs),
        .clk_o (rx_clk)
    );

    sclk_sel4 #(.INVERT(1'b0), .SEL_W(SEL_W)) u_tx_sel (
        .sel   (cfg.tx_src),
        .src   (tx_srcs),
        .clk_o (tx_clk)
    );

    sclk_pin_ctl u_pin (
        .cfg        (cfg),
        .osc_clk    (osc_clk),
        .osc_en     (osc_en),
        .txc        (tx_clk),
        .brg_clk    (brg_clk),
        .pll_rx_clk (pll_rx_clk),
        .oe         (bpin_oe),
        .pin_o      (bpin_out)
    );

    // R4: a driven pin is never a clock source
    a_r4_oe_not_source: assert property (@(posedge clk) disable iff (!rst_n)
        bpin_oe |-> (cfg.rx_src != SRC_BPIN && cfg.tx_src != SRC_BPIN && cfg.pin_req));

    // R6: stopped oscillator shows as a steady high
    a_r6_osc_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bpin_oe && cfg.pin_src == PO_OSC && !osc_en) |-> bpin_out);

    // R10: DPLL transmit output reaches the pin through the transmit path
    a_r10_pll_tx_on_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (bpin_oe && cfg.pin_src == PO_TXC && cfg.tx_src == SRC_PLL) |-> (bpin_out == pll_tx_clk));

    // R7: an undriven pin presents 0
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bpin_oe |-> !bpin_out);

    // R2: receive path is the inverse of its chosen pin source
    a_r2_rx_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.rx_src == SRC_XPIN) |-> (rx_clk != xpin_clk));

endmodule

// File: tb/sclk_route_tb.sv
`timescale 1ns/1ps
module sclk_route_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [3:0] run_en = '0;
    logic       osc_clk = 0, osc_en = 0, brg_clk = 0, pll_rx_clk = 0;
    logic       pll_tx_clk = 0, xpin_clk = 0, bpin_in = 0;
    logic       rx_clk, tx_clk, bpin_oe, bpin_out, cfg_err;

    int errors = 0;
    int checks = 0;
    int cfg_m  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sclk_route u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .run_en(run_en), .osc_clk(osc_clk), .osc_en(osc_en), .brg_clk(brg_clk),
        .pll_rx_clk(pll_rx_clk), .pll_tx_clk(pll_tx_clk), .xpin_clk(xpin_clk),
        .bpin_in(bpin_in), .rx_clk(rx_clk), .tx_clk(tx_clk), .bpin_oe(bpin_oe),
        .bpin_out(bpin_out), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cfg=%02h actual=%0d expected=%0d", tag, cfg_m, act, exp);
        end
    endtask

    function automatic int pick(input int code, input int a0, input int a1,
                                input int a2, input int a3);
        case (code)
            0: return a0;
            1: return a1;
            2: return a2;
            default: return a3;
        endcase
    endfunction

    // compare every output against the model for the present inputs
    task automatic compare(input string ctx);
        int rs, ts, rx_e, tx_e, oe_e, out_e, drv;
        rs   = (cfg_m >> 5) & 3;
        ts   = (cfg_m >> 3) & 3;
        rx_e = 1 - pick(rs, xpin_clk, bpin_in, brg_clk, pll_rx_clk);
        tx_e = pick(ts, xpin_clk, bpin_in, brg_clk, pll_tx_clk);
        oe_e = (((cfg_m >> 2) & 1) == 1 && rs != 1 && ts != 1) ? 1 : 0;
        drv  = pick(cfg_m & 3, osc_en ? int'(osc_clk) : 1, tx_e, brg_clk, pll_rx_clk);
        out_e = oe_e ? drv : 0;
        chk({"R2 rx_clk ", ctx}, rx_clk, rx_e);
        chk({"R3 tx_clk ", ctx}, tx_clk, tx_e);
        chk({"R4 bpin_oe ", ctx}, bpin_oe, oe_e);
        if (oe_e == 0)
            chk({"R7 bpin_out ", ctx}, bpin_out, 0);
        else if ((cfg_m & 3) == 0 && !osc_en)
            chk({"R6 bpin_out ", ctx}, bpin_out, 1);
        else if ((cfg_m & 3) == 1 && ts == 3)
            chk({"R10 bpin_out ", ctx}, bpin_out, out_e);
        else
            chk({"R5 bpin_out ", ctx}, bpin_out, out_e);
    endtask

    task automatic sweep(input string ctx);
        for (int c = 0; c < 128; c++) begin
            @(negedge clk);
            {osc_clk, osc_en, brg_clk, pll_rx_clk, pll_tx_clk, xpin_clk, bpin_in} = 7'(c);
            #1;
            compare(ctx);
            if (c == 0) chk({"R9 cfg_err quiet ", ctx}, cfg_err, 0);
        end
    endtask

    task automatic write_cfg(input int v, input int run);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 8'(v);
        run_en    = 4'(run);
        @(negedge clk);
        cfg_we = 1'b0;
        run_en = '0;
        cfg_m  = v & 8'h7f;   // R8: bit 7 dropped in the model
        #1;
        chk("R9 cfg_err after write", cfg_err, (run != 0) ? 1 : 0);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 reset bpin_oe", bpin_oe, 0);
        chk("R1 reset cfg_err", cfg_err, 0);
        chk("R1 reset tx_clk from xpin", tx_clk, xpin_clk);
        chk("R1 reset rx_clk inverse of xpin", rx_clk, 1 - xpin_clk);
        sweep("R1 reset state");

        // R8: every write value, bit 7 included, then a hold sweep
        for (int v = 0; v < 256; v++) begin
            write_cfg(v, 0);
            sweep((v >= 128) ? "R8 spare bit set" : "R8 hold");
        end

        // R9: writes with each downstream enable high are flagged and stored
        for (int k = 0; k < 4; k++) begin
            write_cfg(8'h1d + k, 1 << k);
            @(negedge clk);
            #1;
            chk("R9 flag one cycle only", cfg_err, 0);
            compare("R9 flagged write stored");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule